// File: doc/BRIEF.md
# IDE Strobe Sequencer for a 68000-Style Expansion Bus

This block connects an asynchronous 68000-style expansion bus to two IDE channels. It watches the address strobe and the upper address bits. When an access falls inside the board's IDE register window, it drives a chip select for the addressed channel and register bank. It also places the IDE read and write strobes on fixed bus states, so that the drive sees a settled address before any strobe. Alongside the strobes it drives the enable and the direction of the data buffers that sit between the bus and the drive cable.

The board's base address comes in as an input, because it is assigned at run time. The bus state is tracked only from rising edges of the CPU clock. A rising edge begins the even states S0, S2, S4 and S6. The address strobe is asserted during S2, so the first rising edge that samples it low is the start of S4. All selects and enables are gated combinationally by the address strobe, so they all drop in the same state in which the strobe is released. A separate activity output per channel can drive an indicator.

Top module: `ide_strobe_seq`

## Requirements
- R1: `board_sel_n` is low exactly when `as_n` is low and `addr_hi[23:16]` equals `base_addr`.
- R2: The IDE window is a board access with `addr_hi[15]`=1. Inside the window, `addr_hi[14]` picks the channel (0 primary = index 0, 1 secondary = index 1) and `addr_hi[13]` picks the bank (0 drives `cs0_n`, 1 drives `cs1_n`). At most one select is low at a time. A board access with `addr_hi[15]`=0 drives no IDE output.
- R3: A state counter is cleared at every rising edge that samples `as_n` high. It counts rising edges that sample `as_n` low (value 1 = S4/S5, 2 = S6/S7, saturating at 7). The address strobe is never sampled on a falling edge.
- R4: For a read in the window (`rw`=1), `ior_n` is low from S4 (counter >= 1) and is never low in the states before the first rising edge that sees the address strobe.
- R5: For a write in the window (`rw`=0), `iow_n` is low from S4 (counter >= 1) and never earlier.
- R6: For a read in the window, `buf_oe_n` goes low combinationally as soon as `uds_n` or `lds_n` is low, even before S4.
- R7: For a read in the window, `buf_oe_n` is low while the counter is 1 (S4/S5) even with both data strobes high. At other counter values it follows the data strobes.
- R8: For a write in the window, `buf_oe_n` is low exactly while `iow_n` is low.
- R9: `buf_dir` is 1 for reads (toward the bus) and 0 for writes. It is captured at the first rising edge of the access and held stable while `buf_oe_n` is low.
- R10: With `as_n` high, every select, strobe and buffer enable is inactive (high) in the same state, without waiting for a clock edge.
- R11: `act[i]` is high exactly while `cs0_n[i]` or `cs1_n[i]` is low.
- R12: Reset is synchronous and active low. While `rst_n` is low the counter stays at 0, so neither IDE strobe asserts even with the address strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Bus address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | Bus direction, 1 = read |
| addr_hi | input | 11 | Bus address bits 23..13 |
| base_addr | input | 8 | Assigned board base (address bits 23..16) |
| board_sel_n | output | 1 | Board selected, active low |
| cs0_n | output | 2 | Task-file bank select per channel, active low |
| cs1_n | output | 2 | Control bank select per channel, active low |
| ior_n | output | 1 | IDE read strobe, active low |
| iow_n | output | 1 | IDE write strobe, active low |
| buf_oe_n | output | 1 | Data buffer enable, active low |
| buf_dir | output | 1 | Data buffer direction, 1 = drive toward bus |
| act | output | 2 | Per-channel activity |

## Verification
On every clock edge the assertions check the following properties:
- No strobe appears before a rising edge has sampled the address strobe.
- Both strobes are never low together.
- Everything is released while the address strobe is high.
- The selects are one-hot.
- The direction holds while the buffers are enabled.
- The activity outputs track the selects.

The early read enable depends on the data strobes before S4, and the S4-only enable of a read with no data strobe has an exact per-state shape. Only the bench's state-by-state scenarios show these two behaviours. The same applies to the counter saturating on long cycles, to reset holding off the strobes, and to the address decode for foreign and flash addresses.

// File: rtl/ide_seq_pkg.sv
// Package: shared constants and the decoded-select type for the IDE strobe sequencer.
// Assumes: two IDE channels, each with two register banks.
package ide_seq_pkg;
    localparam int NCH = 2;

    // Result of the address decode for the current bus access.
    typedef struct packed {
        logic board;   // access hits the board window (qualified by address strobe)
        logic ide;     // access hits the IDE register window
        logic chan;    // 0 = primary, 1 = secondary
        logic cs1;     // 0 = task-file bank, 1 = control bank
    } sel_t;
endpackage

// File: rtl/ide_addr_decode.sv
// Module: ide_addr_decode
// Purpose: combinational decode of the upper bus address against the board base.
// Assumes: the top BASE_W bits of addr_hi are compared with the base. The next
// three bits below them are, in falling order: IDE window, channel and bank.
// Every select is qualified by the address strobe.
module ide_addr_decode
    import ide_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 8
) (
    input  logic                            as_n,
    input  logic [ADDR_W-1:ADDR_W-BASE_W-3] addr_hi,
    input  logic [BASE_W-1:0]               base_addr,
    output sel_t                            sel
);
    localparam int LSB = ADDR_W - BASE_W - 3;

    // Decode board hit, IDE window, channel and bank.
    always_comb begin
        sel.board = !as_n && (addr_hi[ADDR_W-1 -: BASE_W] == base_addr);
        sel.ide   = sel.board && addr_hi[LSB+2];
        sel.chan  = addr_hi[LSB+1];
        sel.cs1   = addr_hi[LSB];
    end
endmodule

// File: rtl/ide_bus_phase.sv
// Module: ide_bus_phase
// Purpose: tracks the bus state from rising CPU clock edges only.
// Assumes: the first rising edge that samples the address strobe low starts S4.
// The counter saturates and clears at any rising edge that samples the
// strobe high. The bus direction is captured on that first edge.
module ide_bus_phase #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             rw,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_q
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // Bus-state counter: clear when idle, count and saturate during an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (as_n) begin
            cnt <= '0;
        end else if (cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Direction latch: capture the bus direction at the first edge of an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b1;
        end else if (!as_n && cnt == '0) begin
            dir_q <= rw;
        end
    end
endmodule

// File: rtl/ide_strobe_gen.sv
// Module: ide_strobe_gen
// Purpose: builds the chip selects, IDE strobes, buffer enable and direction from
// the decoded select, the bus-state counter and the data strobes.
// Assumes: sel.ide is already qualified by the address strobe, so every output
// drops combinationally when the strobe rises.
module ide_strobe_gen
    import ide_seq_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int RD_START = 1,
    parameter int WR_START = 1
) (
    input  logic             uds_n,
    input  logic             lds_n,
    input  logic             rw,
    input  sel_t             sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_q,
    output logic [NCH-1:0]   cs0_n,
    output logic [NCH-1:0]   cs1_n,
    output logic [NCH-1:0]   act,
    output logic             ior_n,
    output logic             iow_n,
    output logic             buf_oe_n,
    output logic             buf_dir
);
    localparam logic [CNT_W-1:0] RD_C = CNT_W'(RD_START);
    localparam logic [CNT_W-1:0] WR_C = CNT_W'(WR_START);
    localparam logic [CNT_W-1:0] S4_C = CNT_W'(1);

    logic dir;
    logic ds_any;
    logic rd_on;
    logic wr_on;

    // Direction: live bus direction until the first edge, latched value after it.
    always_comb begin
        dir    = (cnt == '0) ? rw : dir_q;
        ds_any = !uds_n || !lds_n;
    end

    // Strobes: read and write strobes start only once the counter reaches their state.
    always_comb begin
        rd_on = sel.ide && dir && (cnt >= RD_C);
        wr_on = sel.ide && !dir && (cnt >= WR_C);
        ior_n = !rd_on;
        iow_n = !wr_on;
    end

    // Buffers: reads open on a data strobe or in S4; writes open with the write strobe.
    always_comb begin
        if (dir) begin
            buf_oe_n = !(sel.ide && (ds_any || cnt == S4_C));
        end else begin
            buf_oe_n = !wr_on;
        end
        buf_dir = dir;
    end

    // Per-channel selects and activity.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit_ch;
        // Channel select: the channel hit picks one of the two banks.
        always_comb begin
            hit_ch   = sel.ide && (sel.chan == 1'(g));
            cs0_n[g] = !(hit_ch && !sel.cs1);
            cs1_n[g] = !(hit_ch && sel.cs1);
            act[g]   = hit_ch;
        end
    end
endmodule

// File: rtl/ide_strobe_seq.sv
// Module: ide_strobe_seq (top)
// Purpose: sequences the IDE chip selects, strobes and data buffers for accesses
// from a 68000-style expansion bus into the board's IDE window.
// Assumes: clk is the CPU clock, and the rising edges begin the even bus states.
// rw and the address stay stable while the address strobe is low.
// base_addr is stable between accesses.
module ide_strobe_seq
    import ide_seq_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int BASE_W   = 8,
    parameter int CNT_W    = 3,
    parameter int RD_START = 1,
    parameter int WR_START = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            as_n,
    input  logic                            uds_n,
    input  logic                            lds_n,
    input  logic                            rw,
    input  logic [ADDR_W-1:ADDR_W-BASE_W-3] addr_hi,
    input  logic [BASE_W-1:0]               base_addr,
    output logic                            board_sel_n,
    output logic [NCH-1:0]                  cs0_n,
    output logic [NCH-1:0]                  cs1_n,
    output logic                            ior_n,
    output logic                            iow_n,
    output logic                            buf_oe_n,
    output logic                            buf_dir,
    output logic [NCH-1:0]                  act
);
    sel_t             sel;
    logic [CNT_W-1:0] cnt;
    logic             dir_q;

    ide_addr_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_dec (
        .as_n      (as_n),
        .addr_hi   (addr_hi),
        .base_addr (base_addr),
        .sel       (sel)
    );

    ide_bus_phase #(.CNT_W(CNT_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .as_n  (as_n),
        .rw    (rw),
        .cnt   (cnt),
        .dir_q (dir_q)
    );

    ide_strobe_gen #(.CNT_W(CNT_W), .RD_START(RD_START), .WR_START(WR_START)) u_gen (
        .uds_n    (uds_n),
        .lds_n    (lds_n),
        .rw       (rw),
        .sel      (sel),
        .cnt      (cnt),
        .dir_q    (dir_q),
        .cs0_n    (cs0_n),
        .cs1_n    (cs1_n),
        .act      (act),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .buf_oe_n (buf_oe_n),
        .buf_dir  (buf_dir)
    );

    // Board select output: active-low view of the decoded board hit.
    always_comb board_sel_n = !sel.board;
endmodule

// File: rtl/ide_strobe_seq_chk.sv
// Module: ide_strobe_seq_chk
// Purpose: concurrent checks on the sequencer's ports, attached by bind.
// Assumes: sampled on the CPU clock; all checks are disabled during reset.
module ide_strobe_seq_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           as_n,
    input logic           board_sel_n,
    input logic [NCH-1:0] cs0_n,
    input logic [NCH-1:0] cs1_n,
    input logic           ior_n,
    input logic           iow_n,
    input logic           buf_oe_n,
    input logic           buf_dir,
    input logic [NCH-1:0] act
);
    // R4: no read strobe unless an earlier edge already saw the address strobe.
    a_r4_rd_after_as: assert property (@(posedge clk) disable iff (!rst_n)
        !ior_n |-> $past(!as_n));

    // R5: no write strobe unless an earlier edge already saw the address strobe.
    a_r5_wr_after_as: assert property (@(posedge clk) disable iff (!rst_n)
        !iow_n |-> $past(!as_n));

    // R4 / R5: read and write strobes are never low together.
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ior_n && !iow_n));

    // R10: everything released while the address strobe is high.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (board_sel_n && ior_n && iow_n && buf_oe_n
                  && (&cs0_n) && (&cs1_n)));

    // R2: at most one chip select is active.
    a_r2_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{cs0_n, cs1_n}));

    // R9: direction held while the buffers stay enabled.
    a_r9_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_oe_n && $past(!buf_oe_n)) |-> $stable(buf_dir));

    // R9: a read strobe always sees the buffers pointing at the bus.
    a_r9_rd_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !ior_n |-> buf_dir);

    // R11: activity reflects the selects of each channel.
    a_r11_act: assert property (@(posedge clk) disable iff (!rst_n)
        act == ~(cs0_n & cs1_n));
endmodule

bind ide_strobe_seq ide_strobe_seq_chk #(.NCH(ide_seq_pkg::NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_n        (as_n),
    .board_sel_n (board_sel_n),
    .cs0_n       (cs0_n),
    .cs1_n       (cs1_n),
    .ior_n       (ior_n),
    .iow_n       (iow_n),
    .buf_oe_n    (buf_oe_n),
    .buf_dir     (buf_dir),
    .act         (act)
);

// File: tb/ide_strobe_seq_bench.sv
module ide_strobe_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic        rw = 1'b1;
    logic [23:13] addr_hi = '0;
    logic [7:0]  base_addr = 8'hE9;
    logic        board_sel_n;
    logic [1:0]  cs0_n;
    logic [1:0]  cs1_n;
    logic        ior_n;
    logic        iow_n;
    logic        buf_oe_n;
    logic        buf_dir;
    logic [1:0]  act;

    int checks = 0;
    int fails  = 0;
    int tb_cnt = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ide_strobe_seq u_ide_strobe_seq (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rw(rw), .addr_hi(addr_hi), .base_addr(base_addr),
        .board_sel_n(board_sel_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .ior_n(ior_n), .iow_n(iow_n), .buf_oe_n(buf_oe_n),
        .buf_dir(buf_dir), .act(act)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (cnt=%0d)", req, got, exp, tb_cnt);
        end
    endtask

    // Expected-value functions built from the requirements.
    function automatic bit f_board();
        return !as_n && addr_hi[23:16] == base_addr;           // R1
    endfunction
    function automatic bit f_ide();
        return f_board() && addr_hi[15];                       // R2
    endfunction
    function automatic logic [1:0] f_cs(input bit bank);
        logic [1:0] v = 2'b11;
        if (f_ide() && addr_hi[13] == bank) v[addr_hi[14]] = 1'b0;
        return v;
    endfunction
    function automatic bit f_boe(input bit rd);
        if (!f_ide()) return 1'b1;
        if (rd) return !(!uds_n || !lds_n || tb_cnt == 1);    // R6, R7
        return !(tb_cnt >= 1);                                 // R8
    endfunction

    // Compare every output with its expected value at the current state.
    task automatic check_all(input bit rd);
        string tag;
        tag = as_n ? "R10" : "R1";
        chk(tag, {7'd0, board_sel_n}, {7'd0, !f_board()});
        tag = as_n ? "R10" : "R2";
        chk(tag, {6'd0, cs0_n}, {6'd0, f_cs(1'b0)});
        chk(tag, {6'd0, cs1_n}, {6'd0, f_cs(1'b1)});
        tag = as_n ? "R10" : "R3/R4";
        chk(tag, {7'd0, ior_n}, {7'd0, !(f_ide() && rd && tb_cnt >= 1)});
        tag = as_n ? "R10" : "R3/R5";
        chk(tag, {7'd0, iow_n}, {7'd0, !(f_ide() && !rd && tb_cnt >= 1)});
        tag = as_n ? "R10" : (rd ? "R6/R7" : "R8");
        chk(tag, {7'd0, buf_oe_n}, {7'd0, f_boe(rd)});
        if (!as_n) chk("R9", {7'd0, buf_dir}, {7'd0, rd});
        chk("R11", {6'd0, act}, {6'd0, ~(f_cs(1'b0) & f_cs(1'b1))});
    endtask

    // One bus access: len rising edges with the address strobe low.
    task automatic bus_cycle(input logic [10:0] a, input bit rd,
                             input logic [1:0] ds, input int len);
        @(negedge clk);
        addr_hi = a; rw = rd; as_n = 1'b0; tb_cnt = 0;
        if (rd) {uds_n, lds_n} = ~ds;
        #1 check_all(rd);
        for (int k = 1; k <= len; k++) begin
            @(posedge clk);
            @(negedge clk);
            tb_cnt = (k > 7) ? 7 : k;                          // R3 saturation
            if (!rd && k == 1) {uds_n, lds_n} = ~ds;
            #1 check_all(rd);
        end
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        #1 check_all(rd);                                      // R10 immediate release
        @(posedge clk);
        @(negedge clk);
        tb_cnt = 0;
        #1 check_all(rd);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1de0));
        // R12: reset holds the counter, no strobe despite a low address strobe.
        repeat (2) @(posedge clk);
        @(negedge clk);
        addr_hi = {8'hE9, 3'b100}; rw = 1'b1; as_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", {7'd0, ior_n}, 8'd1);
        rw = 1'b0;
        #1 chk("R12", {7'd0, iow_n}, 8'd1);
        as_n = 1'b1; rw = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tb_cnt = 0;
        #1 check_all(1'b1);

        // Directed corners.
        bus_cycle({8'hE9, 3'b100}, 1'b1, 2'b00, 3);  // R7: read, no data strobe
        bus_cycle({8'hE9, 3'b100}, 1'b1, 2'b01, 3);  // R6: early read enable
        bus_cycle({8'hE9, 3'b111}, 1'b0, 2'b11, 3);  // R5, R8: write secondary bank 1
        bus_cycle({8'hE9, 3'b011}, 1'b1, 2'b11, 2);  // R2: flash half, no IDE
        bus_cycle({8'h12, 3'b100}, 1'b1, 2'b11, 2);  // R1: foreign base
        bus_cycle({8'hE9, 3'b110}, 1'b1, 2'b10, 10); // R3: saturating long read

        // Constrained random accesses.
        for (int i = 0; i < 200; i++) begin
            logic [10:0] a;
            a[2:0]  = 3'($urandom_range(0, 7));
            a[10:3] = ($urandom_range(0, 3) != 0) ? base_addr : 8'($urandom_range(0, 255));
            if (i == 100) base_addr = 8'h40;
            bus_cycle(a, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                      $urandom_range(1, 5));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule